// File: doc/BRIEF.md
# Registered Fan-out Buffer with Parity

This block sits on the command/address path of a registered memory module. On each rising clock edge it takes in a 28-bit word and drives two identical registered copies of it, A and B. Each copy feeds half of the module's load. The word reaches the outputs only when at least one enabled chip select is asserted (low). When no enabled chip select is asserted, the outputs keep their last value, which saves switching power. The two clock-enable bits and the two termination-control bits are not gated: they are registered on every edge. The raw chip-select lines are also registered on every edge, on both copies.

The memory controller sends an even-parity bit one cycle after the word it covers. The block keeps the low 22 bits of each accepted word for one extra stage and compares them with that late bit. A mismatch drives an active-low error flag. The flag stays low for a minimum hold window, and a repeated error restarts the window. A program input decides whether the second pair of chip selects takes part in gating. The external reset is active low. It forces the outputs at once, and its release is synchronised to the clock.

Top module: `rfb_fanout_reg`

## Requirements
- R1: While `rst_n` is low, every data, clock-enable, termination and chip-select output is 0 and `err_n` is 1. This takes effect without waiting for a clock edge.
- R2: On an edge where any enabled chip select is 0, `data_a` and `data_b` both take the value of `din` sampled at that edge.
- R3: On an edge where every enabled chip select is 1, `data_a` and `data_b` keep their previous values.
- R4: `cke_a`, `cke_b`, `odt_a` and `odt_b` take `cke_in` and `odt_in` on every edge, whatever the chip selects are.
- R5: `cs_a_n` and `cs_b_n` take `cs_n` on every edge, all four bits.
- R6: Bits 0 and 1 of `cs_n` are always enabled. Bits 2 and 3 are enabled only when `cs_pair_en` is 1; when it is 0, a low level on them neither enables capture nor triggers a parity check.
- R7: Parity is even. Let m be an edge where capture is enabled. `par_in` is sampled at edge m+1. If the XOR of `din[21:0]` taken at edge m and that `par_in` is 1, `err_n` goes low right after edge m+2.
- R8: An isolated error holds `err_n` low for exactly two clock cycles. It then returns to 1.
- R9: An error detected while `err_n` is already low restarts the two-cycle hold from that error.
- R10: A parity mismatch for a word taken on an edge with no enabled chip select asserted is ignored, and `err_n` stays 1.
- R11: Taking `rst_n` low while the error hold is running forces `err_n` to 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| din | input | 28 | Word to be registered; bits 21:0 are covered by parity |
| cke_in | input | 2 | Clock-enable bits, never gated |
| odt_in | input | 2 | Termination-control bits, never gated |
| cs_n | input | 4 | Active-low chip selects |
| cs_pair_en | input | 1 | 1 lets cs_n[3:2] take part in gating |
| par_in | input | 1 | Even-parity bit for the word taken one edge earlier |
| data_a | output | 28 | Registered word, copy A |
| data_b | output | 28 | Registered word, copy B |
| cke_a | output | 2 | Registered clock enables, copy A |
| cke_b | output | 2 | Registered clock enables, copy B |
| odt_a | output | 2 | Registered termination bits, copy A |
| odt_b | output | 2 | Registered termination bits, copy B |
| cs_a_n | output | 4 | Registered chip selects, copy A |
| cs_b_n | output | 4 | Registered chip selects, copy B |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The embedded properties check four things on every clock: capture when selected, freezing when deselected, ungated pass-through of the control bits, and agreement between the two copies. They also check that the error flag never stays low for less than two cycles, and that every falling edge of the flag traces back to a registered mismatch. Some behaviour only the bench scenarios can show. These are the exact point in time where the late parity bit lines up with its word, the masking of the upper chip-select pair, the restart of the hold by back-to-back errors, the dropping of parity on deselected cycles, and a reset landing in the middle of a hold. The bench checks each of these against a cycle-by-cycle model, both in directed sequences and in a long run with random stimulus.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int unsigned CKE_W     = 2;
  localparam int unsigned ODT_W     = 2;
  localparam int unsigned CS_W      = 4;
  localparam int unsigned CS_BASE_W = 2;

  typedef struct packed {
    logic [CKE_W-1:0] cke;
    logic [ODT_W-1:0] odt;
  } ctl_t;
endpackage

// File: rtl/rfb_rst_sync.sv
module rfb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;
endmodule

// File: rtl/rfb_cs_gate.sv
module rfb_cs_gate #(
  parameter int unsigned CS_W   = 4,
  parameter int unsigned BASE_W = 2
) (
  input  logic [CS_W-1:0] cs_n,
  input  logic            pair_en,
  output logic            sel
);
  logic [CS_W-1:0] enable_mask;

  // Low chip selects are always enabled; the upper ones need pair_en.
  for (genvar i = 0; i < CS_W; i++) begin : g_mask
    if (i < BASE_W) begin : g_base
      assign enable_mask[i] = 1'b1;
    end else begin : g_ext
      assign enable_mask[i] = pair_en;
    end
  end

  always_comb begin
    sel = |(~cs_n & enable_mask);
  end
endmodule

// File: rtl/rfb_out_bank.sv
module rfb_out_bank
  import rfb_pkg::*;
#(
  parameter int unsigned DATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  input  ctl_t              ctl_in,
  input  logic [CS_W-1:0]   cs_in,
  output logic [DATA_W-1:0] data_q,
  output ctl_t              ctl_q,
  output logic [CS_W-1:0]   cs_q
);
  logic [DATA_W-1:0] data_d;
  ctl_t              ctl_d;
  logic [CS_W-1:0]   cs_d;

  always_comb begin
    data_d = data_q;
    if (sel) begin
      data_d = din;
    end
    ctl_d = ctl_in;
    cs_d  = cs_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= '0;
      cs_q   <= '0;
    end else begin
      data_q <= data_d;
      ctl_q  <= ctl_d;
      cs_q   <= cs_d;
    end
  end

  AST_CAPTURE_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> (data_q == $past(din)));  // R2
  AST_HOLD_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(data_q));  // R3
  AST_CTL_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ctl_q == $past(ctl_in)));  // R4
endmodule

// File: rtl/rfb_parity_chk.sv
module rfb_parity_chk #(
  parameter int unsigned PAR_W    = 22,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [PAR_W-1:0] par_bits,
  input  logic             par_in,
  output logic             err_n
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

  logic             px_q, px_d;
  logic             act_q, act_d;
  logic             mis_q, mis_d;
  logic             low_q, low_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    px_d  = ^par_bits;
    act_d = sel;
    mis_d = act_q & (px_q ^ par_in);
    low_d = 1'b0;
    cnt_d = cnt_q;
    if (mis_q) begin
      low_d = 1'b1;
      cnt_d = HOLD_LOAD;
    end else if (cnt_q != '0) begin
      low_d = 1'b1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q  <= 1'b0;
      act_q <= 1'b0;
      mis_q <= 1'b0;
      low_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      px_q  <= px_d;
      act_q <= act_d;
      mis_q <= mis_d;
      low_q <= low_d;
      cnt_q <= cnt_d;
    end
  end

  assign err_n = ~low_q;

  AST_ERR_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> !err_n);  // R8
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> $past(mis_q));  // R7
endmodule

// File: rtl/rfb_fanout_reg.sv
module rfb_fanout_reg
  import rfb_pkg::*;
#(
  parameter int unsigned DATA_W   = 28,
  parameter int unsigned PAR_W    = 22,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [CKE_W-1:0]  cke_in,
  input  logic [ODT_W-1:0]  odt_in,
  input  logic [CS_W-1:0]   cs_n,
  input  logic              cs_pair_en,
  input  logic              par_in,
  output logic [DATA_W-1:0] data_a,
  output logic [DATA_W-1:0] data_b,
  output logic [CKE_W-1:0]  cke_a,
  output logic [CKE_W-1:0]  cke_b,
  output logic [ODT_W-1:0]  odt_a,
  output logic [ODT_W-1:0]  odt_b,
  output logic [CS_W-1:0]   cs_a_n,
  output logic [CS_W-1:0]   cs_b_n,
  output logic              err_n
);
  localparam int unsigned NUM_COPIES = 2;

  logic rst_s_n;
  logic sel;
  ctl_t ctl_in;

  logic [DATA_W-1:0] data_q [NUM_COPIES];
  ctl_t              ctl_q  [NUM_COPIES];
  logic [CS_W-1:0]   cs_q   [NUM_COPIES];

  rfb_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_s_n)
  );

  rfb_cs_gate #(
    .CS_W   (CS_W),
    .BASE_W (CS_BASE_W)
  ) u_cs_gate (
    .cs_n    (cs_n),
    .pair_en (cs_pair_en),
    .sel     (sel)
  );

  assign ctl_in = '{cke: cke_in, odt: odt_in};

  for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
    rfb_out_bank #(
      .DATA_W (DATA_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .sel    (sel),
      .din    (din),
      .ctl_in (ctl_in),
      .cs_in  (cs_n),
      .data_q (data_q[g]),
      .ctl_q  (ctl_q[g]),
      .cs_q   (cs_q[g])
    );
  end

  rfb_parity_chk #(
    .PAR_W    (PAR_W),
    .HOLD_CYC (HOLD_CYC)
  ) u_parity (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .sel      (sel),
    .par_bits (din[PAR_W-1:0]),
    .par_in   (par_in),
    .err_n    (err_n)
  );

  assign data_a = data_q[0];
  assign data_b = data_q[1];
  assign cke_a  = ctl_q[0].cke;
  assign cke_b  = ctl_q[1].cke;
  assign odt_a  = ctl_q[0].odt;
  assign odt_b  = ctl_q[1].odt;
  assign cs_a_n = cs_q[0];
  assign cs_b_n = cs_q[1];

  AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (!rst_s_n)
    (data_a == data_b) && (cs_a_n == cs_b_n));  // R2
endmodule

// File: tb/tb_rfb_fanout_reg.sv
`timescale 1ns/1ps
module tb_rfb_fanout_reg;
  localparam int DATA_W = 28;
  localparam int PAR_W  = 22;
  localparam int HOLD   = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DATA_W-1:0] din;
  logic [1:0]        cke_in, odt_in;
  logic [3:0]        cs_n;
  logic              cs_pair_en, par_in;
  logic [DATA_W-1:0] data_a, data_b;
  logic [1:0]        cke_a, cke_b, odt_a, odt_b;
  logic [3:0]        cs_a_n, cs_b_n;
  logic              err_n;

  rfb_fanout_reg dut (
    .clk(clk), .rst_n(rst_n), .din(din), .cke_in(cke_in), .odt_in(odt_in),
    .cs_n(cs_n), .cs_pair_en(cs_pair_en), .par_in(par_in),
    .data_a(data_a), .data_b(data_b), .cke_a(cke_a), .cke_b(cke_b),
    .odt_a(odt_a), .odt_b(odt_b), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .err_n(err_n)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model state
  logic [DATA_W-1:0] m_data;
  logic [1:0]        m_cke, m_odt;
  logic [3:0]        m_cs;
  logic              m_px, m_act, m_mis, m_low;
  int                m_hold;
  logic              prev_px;
  string             err_tag = "R7";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit sel_of(input logic [3:0] c, input logic pe);
    return !c[0] || !c[1] || (pe && (!c[2] || !c[3]));
  endfunction

  task automatic model_clear();
    m_data = '0; m_cke = '0; m_odt = '0; m_cs = 4'hF;
    m_px = 0; m_act = 0; m_mis = 0; m_low = 0; m_hold = 0; prev_px = 0;
  endtask

  // Drive at a negedge, advance one edge, compare at the next negedge.
  task automatic step(input logic [DATA_W-1:0] d, input logic [1:0] ck, input logic [1:0] od,
                      input logic [3:0] c, input logic pe, input bit flip, input string dtag);
    bit a;
    bit new_mis;
    string t;
    din = d; cke_in = ck; odt_in = od; cs_n = c; cs_pair_en = pe;
    par_in = prev_px ^ flip;
    a = sel_of(c, pe);
    new_mis = m_act && (m_px ^ par_in);
    if (m_mis) begin m_low = 1; m_hold = HOLD - 1; end
    else if (m_hold != 0) begin m_hold--; m_low = 1; end
    else m_low = 0;
    m_mis = new_mis; m_act = a; m_px = ^d[PAR_W-1:0];
    if (a) m_data = d;
    m_cke = ck; m_odt = od; m_cs = c;
    prev_px = ^d[PAR_W-1:0];
    @(posedge clk);
    @(negedge clk);
    t = (dtag != "") ? dtag : (a ? "R2" : "R3");
    chk(data_a == m_data, t, 32'(data_a), 32'(m_data));
    chk(data_b == m_data, t, 32'(data_b), 32'(m_data));
    chk({cke_a, odt_a, cke_b, odt_b} == {m_cke, m_odt, m_cke, m_odt}, "R4",
        {24'h0, cke_a, odt_a, cke_b, odt_b}, {24'h0, m_cke, m_odt, m_cke, m_odt});
    chk({cs_a_n, cs_b_n} == {m_cs, m_cs}, "R5", {24'h0, cs_a_n, cs_b_n}, {24'h0, m_cs, m_cs});
    chk(err_n == !m_low, err_tag, 32'(err_n), 32'(!m_low));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 2'b00, 2'b00, 4'hF, 1'b0, 1'b0, "");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    din = '0; cke_in = '0; odt_in = '0; cs_n = 4'hF; cs_pair_en = 0; par_in = 0;
    #1;
    chk({data_a, data_b} == '0, "R1", 32'(data_a | data_b), 32'h0);
    chk({cke_a, cke_b, odt_a, odt_b, cs_a_n, cs_b_n} == '0, "R1",
        {16'h0, cke_a, cke_b, odt_a, odt_b, cs_a_n, cs_b_n}, 32'h0);
    chk(err_n == 1'b1, "R1", 32'(err_n), 32'h1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R2 capture, R3 hold with changing din
    step(28'hABCDEF1, 2'b01, 2'b10, 4'b1110, 1'b0, 0, "R2");
    step(28'h1234567, 2'b10, 2'b01, 4'b1111, 1'b0, 0, "R3");
    step(28'h7654321, 2'b11, 2'b11, 4'b1111, 1'b1, 0, "R3");
    // R6: upper pair masked, then enabled
    step(28'h0F0F0F0, 2'b00, 2'b01, 4'b1011, 1'b0, 0, "R6");
    step(28'h0F0F0F0, 2'b00, 2'b01, 4'b1011, 1'b1, 0, "R6");
    step(28'h5555555, 2'b01, 2'b00, 4'b0111, 1'b1, 0, "R6");
    idle(3);

    // R7 and R8: one bad parity, flag low for exactly two cycles
    err_tag = "R7";
    step(28'h00000F1, 2'b00, 2'b00, 4'b1101, 1'b0, 0, "");
    step('0, 2'b00, 2'b00, 4'hF, 1'b0, 1'b1, "");
    idle(1);
    chk(err_n == 1'b0, "R7", 32'(err_n), 32'h0);
    err_tag = "R8";
    idle(1);
    chk(err_n == 1'b0, "R8", 32'(err_n), 32'h0);
    idle(1);
    chk(err_n == 1'b1, "R8", 32'(err_n), 32'h1);
    idle(2);

    // R9: back-to-back errors restart the hold
    err_tag = "R9";
    step(28'h0000003, 2'b00, 2'b00, 4'b1110, 1'b0, 0, "");
    step(28'h0000007, 2'b00, 2'b00, 4'b1110, 1'b0, 1, "");
    step('0, 2'b00, 2'b00, 4'hF, 1'b0, 1'b1, "");
    idle(1);
    idle(1);
    chk(err_n == 1'b0, "R9", 32'(err_n), 32'h0);
    idle(4);

    // R10: bad parity after a deselected word is ignored
    err_tag = "R10";
    step(28'h0000001, 2'b00, 2'b00, 4'b1111, 1'b0, 0, "");
    step('0, 2'b00, 2'b00, 4'hF, 1'b0, 1'b1, "");
    idle(3);
    chk(err_n == 1'b1, "R10", 32'(err_n), 32'h1);

    // R11: reset during the hold
    err_tag = "R7";
    step(28'h0000001, 2'b00, 2'b00, 4'b1110, 1'b0, 0, "");
    step('0, 2'b00, 2'b00, 4'hF, 1'b0, 1'b1, "");
    idle(1);
    chk(err_n == 1'b0, "R11", 32'(err_n), 32'h0);
    rst_n = 1'b0;
    #1;
    chk(err_n == 1'b1, "R11", 32'(err_n), 32'h1);
    @(negedge clk);
    do_reset();

    // random phase
    err_tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      if ($urandom % 3 == 0) c = 4'hF;
      step(28'($urandom), 2'($urandom), 2'($urandom), c, 1'($urandom),
           ($urandom % 6) == 0, "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule